// File: doc/BRIEF.md
# Serial Sample Negator for Differential Converter Pairs

This block sits in a serial audio path, where a bit clock, a word select line and one MSB-first data line carry two's-complement samples. It drives two converters that are wired as a differential pair. Both converters share the bit clock and the word select. Only their data lines differ: one line carries each sample unchanged, and the other carries the arithmetic negation of the same sample. Subtracting the two converter outputs in a transformer or an amplifier then doubles the signal and cancels noise that both converters share. Because the negation is exact, the two outputs have no one-LSB DC offset between them.

The data arrives MSB first, so the full word must be present before it can be negated. The block captures each word, transforms it at its last bit, and sends the result out in the same channel slot of the following frame. The unchanged data line passes through a delay line of exactly one frame, so both data lines stay sample-aligned. The most negative input code has no positive counterpart. The block maps it to the most positive code. A mode input selects plain bitwise inversion instead, so that the two methods can be compared on the bench or in a listening test.

Top module: `serial_negator`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0. After reset, every bit position of the first emitted word of each channel on `sd_neg_out` is 0.
- R2: With `mode_neg` = 1, each word received in a channel slot is sent on `sd_neg_out` as its two's-complement negation (modulo 2^WORD), MSB first. It occupies the same bit positions of the same channel slot exactly 2*SLOT bit clocks later.
- R3: `sd_true_out` carries `sd_in` delayed by exactly 2*SLOT bit clocks. Bit positions outside the word are included.
- R4: With `mode_neg` = 1, the most negative code (MSB 1, all other bits 0) is sent as the most positive code (MSB 0, all other bits 1).
- R5: With `mode_neg` = 0, each word is sent as its bitwise complement. The mode is taken from the bit clock on which the word's last bit is sampled.
- R6: A word's MSB is the bit sampled on the second rising bit clock edge after a change of `ws_in`. Its remaining WORD-1 bits follow on consecutive edges. At every other position of the slot, `sd_neg_out` is 0.
- R7: All outputs change on the falling edge of `bck`. Each falling edge presents the values belonging to the preceding rising edge, and `ws_out` equals `ws_in` as sampled on that rising edge.
- R8: A word received while `ws_in` = 0 is sent only in a later `ws_in` = 0 slot, and a word received while `ws_in` = 1 is sent only in a later `ws_in` = 1 slot. The two channels never swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Serial bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `bck` |
| ws_in | input | 1 | Word select: 0 for the left channel, 1 for the right channel |
| sd_in | input | 1 | Serial sample data, MSB first, one bit after each word select change |
| mode_neg | input | 1 | 1 selects arithmetic negation, 0 selects bitwise inversion |
| ws_out | output | 1 | Word select shared by both converters |
| sd_true_out | output | 1 | Unchanged data, delayed by one frame |
| sd_neg_out | output | 1 | Negated (or inverted) data, aligned with `sd_true_out` |

## Verification
The bench builds the block with WORD = 16 and SLOT = 18. It feeds random bits into the two spare positions of every slot. Those bits reach the unchanged path, and they must stay out of the negated path. A slot longer than the word also moves the last word bit away from the word select edge. The bench applies the most negative code in both modes, as well as the most positive code, zero, one and minus one. Mode changes between frames show that the mode is latched per word, and random per-channel words would reveal any swap of the channel slots.

// File: rtl/sneg_pkg.sv
package sneg_pkg;

  // Transform applied to each captured word before it is replayed.
  typedef enum logic {
    XF_INVERT = 1'b0,
    XF_NEGATE = 1'b1
  } xf_mode_e;

endpackage

// File: rtl/sneg_capture.sv
// Finds word boundaries from word select (one-bit delayed framing),
// tracks the bit position inside the word and collects the word MSB first.
module sneg_capture #(
  parameter int WORD = 16
) (
  input  logic                          bck,
  input  logic                          rst_n,
  input  logic                          ws_in,
  input  logic                          sd_in,
  output logic                          bit_act,
  output logic [$clog2(WORD+1)-1:0]     bit_idx,
  output logic                          bit_ch,
  output logic                          word_vld,
  output logic [WORD-1:0]               word
);

  localparam int CW = $clog2(WORD + 1);

  logic          ws_p1_q, ws_p2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ch_q;
  logic [WORD-1:0] sh_q;
  logic          start;

  always_comb begin
    start    = ws_p1_q ^ ws_p2_q;
    bit_idx  = start ? '0 : cnt_q;
    bit_act  = start || (cnt_q < CW'(WORD));
    bit_ch   = start ? ws_p1_q : ch_q;
    word     = {sh_q[WORD-2:0], sd_in};
    word_vld = bit_act && (bit_idx == CW'(WORD - 1));
    cnt_d    = bit_idx + CW'(1);
  end

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      ws_p1_q <= 1'b0;
      ws_p2_q <= 1'b0;
      cnt_q   <= CW'(WORD);
      ch_q    <= 1'b0;
      sh_q    <= '0;
    end else begin
      ws_p1_q <= ws_in;
      ws_p2_q <= ws_p1_q;
      ch_q    <= bit_ch;
      if (bit_act) begin
        cnt_q <= cnt_d;
        sh_q  <= word;
      end
    end
  end

endmodule

// File: rtl/sneg_xform.sv
// Word transform: bitwise complement or saturating two's-complement negation.
module sneg_xform
  import sneg_pkg::*;
#(
  parameter int WORD = 16
) (
  input  xf_mode_e        mode,
  input  logic [WORD-1:0] word,
  output logic [WORD-1:0] res
);

  localparam logic [WORD-1:0] MIN_CODE = {1'b1, {(WORD-1){1'b0}}};
  localparam logic [WORD-1:0] MAX_CODE = ~MIN_CODE;
  localparam logic [WORD-1:0] ONE      = {{(WORD-1){1'b0}}, 1'b1};

  always_comb begin
    if (mode == XF_INVERT) begin
      res = ~word;
    end else if (word == MIN_CODE) begin
      res = MAX_CODE;
    end else begin
      res = ~word + ONE;
    end
  end

endmodule

// File: rtl/sneg_emit.sv
// Per-channel word store, bit replay, one-frame delay of the true line and
// the falling-edge launch stage shared by all three outputs.
module sneg_emit #(
  parameter int WORD = 16,
  parameter int SLOT = 16
) (
  input  logic                      bck,
  input  logic                      rst_n,
  input  logic                      ws_in,
  input  logic                      sd_in,
  input  logic                      bit_act,
  input  logic [$clog2(WORD+1)-1:0] bit_idx,
  input  logic                      bit_ch,
  input  logic                      word_vld,
  input  logic [WORD-1:0]           xf_word,
  output logic                      ws_out,
  output logic                      sd_true_out,
  output logic                      sd_neg_out
);

  localparam int DL = 2 * SLOT;
  localparam int IW = $clog2(WORD);
  localparam int NCH = 2;

  logic [WORD-1:0] hold_w [NCH];
  logic [DL-1:0]   dl_q;
  logic [IW-1:0]   rev;
  logic [WORD-1:0] sel_word;
  logic            neg_bit;
  logic            ws_r_q, true_r_q, neg_r_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WORD-1:0] h_q;
    logic            h_en;
    assign h_en = word_vld && (bit_ch == 1'(c));
    always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) begin
        h_q <= '0;
      end else if (h_en) begin
        h_q <= xf_word;
      end
    end
    assign hold_w[c] = h_q;
  end

  always_comb begin
    sel_word = hold_w[bit_ch];
    rev      = IW'(WORD - 1) - IW'(bit_idx);
    neg_bit  = bit_act ? sel_word[rev] : 1'b0;
  end

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      dl_q     <= '0;
      ws_r_q   <= 1'b0;
      true_r_q <= 1'b0;
      neg_r_q  <= 1'b0;
    end else begin
      dl_q     <= {dl_q[DL-2:0], sd_in};
      ws_r_q   <= ws_in;
      true_r_q <= dl_q[DL-1];
      neg_r_q  <= neg_bit;
    end
  end

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) begin
      ws_out      <= 1'b0;
      sd_true_out <= 1'b0;
      sd_neg_out  <= 1'b0;
    end else begin
      ws_out      <= ws_r_q;
      sd_true_out <= true_r_q;
      sd_neg_out  <= neg_r_q;
    end
  end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
  import sneg_pkg::*;
#(
  parameter int WORD = 16,
  parameter int SLOT = 16
) (
  input  logic bck,
  input  logic rst_n,
  input  logic ws_in,
  input  logic sd_in,
  input  logic mode_neg,
  output logic ws_out,
  output logic sd_true_out,
  output logic sd_neg_out
);

  localparam int CW = $clog2(WORD + 1);

  logic            w_bit_act;
  logic [CW-1:0]   w_bit_idx;
  logic            w_bit_ch;
  logic            w_word_vld;
  logic [WORD-1:0] w_word;
  logic [WORD-1:0] w_xf;
  xf_mode_e        w_mode;

  assign w_mode = xf_mode_e'(mode_neg);

  sneg_capture #(.WORD(WORD)) u_cap (
    .bck      (bck),
    .rst_n    (rst_n),
    .ws_in    (ws_in),
    .sd_in    (sd_in),
    .bit_act  (w_bit_act),
    .bit_idx  (w_bit_idx),
    .bit_ch   (w_bit_ch),
    .word_vld (w_word_vld),
    .word     (w_word)
  );

  sneg_xform #(.WORD(WORD)) u_xf (
    .mode (w_mode),
    .word (w_word),
    .res  (w_xf)
  );

  sneg_emit #(.WORD(WORD), .SLOT(SLOT)) u_emit (
    .bck         (bck),
    .rst_n       (rst_n),
    .ws_in       (ws_in),
    .sd_in       (sd_in),
    .bit_act     (w_bit_act),
    .bit_idx     (w_bit_idx),
    .bit_ch      (w_bit_ch),
    .word_vld    (w_word_vld),
    .xf_word     (w_xf),
    .ws_out      (ws_out),
    .sd_true_out (sd_true_out),
    .sd_neg_out  (sd_neg_out)
  );

endmodule

// File: rtl/sneg_chk.sv
module sneg_chk #(
  parameter int WORD = 16
) (
  input logic            bck,
  input logic            rst_n,
  input logic            ws_in,
  input logic            mode_neg,
  input logic            ws_out,
  input logic            sd_true_out,
  input logic            sd_neg_out,
  input logic            bit_act,
  input logic            word_vld,
  input logic [WORD-1:0] cap_word,
  input logic [WORD-1:0] xf_word
);

  localparam logic [WORD-1:0] MIN_CODE = {1'b1, {(WORD-1){1'b0}}};
  localparam logic [WORD-1:0] MAX_CODE = ~MIN_CODE;

  logic            armed_q;
  logic [WORD-1:0] sum_w;
  logic [WORD-1:0] diff_w;

  assign sum_w  = cap_word + xf_word;
  assign diff_w = cap_word ^ xf_word;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always @(posedge bck) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!ws_out && !sd_true_out && !sd_neg_out); // R1
    end
  end

  AST_SUM_ZERO: assert property (@(posedge bck) disable iff (!rst_n)
    (word_vld && mode_neg && cap_word != MIN_CODE) |-> (sum_w == '0)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge bck) disable iff (!rst_n)
    (word_vld && mode_neg && cap_word == MIN_CODE) |-> (xf_word == MAX_CODE)); // R4

  AST_INV_MODE: assert property (@(posedge bck) disable iff (!rst_n)
    (word_vld && !mode_neg) |-> (diff_w == '1)); // R5

  AST_PAD_QUIET: assert property (@(posedge bck) disable iff (!rst_n)
    !bit_act |=> !sd_neg_out); // R6

  AST_WS_FOLLOW: assert property (@(posedge bck) disable iff (!rst_n)
    armed_q |-> (ws_out == $past(ws_in))); // R7

endmodule

bind serial_negator sneg_chk #(.WORD(WORD)) u_chk (
  .bck         (bck),
  .rst_n       (rst_n),
  .ws_in       (ws_in),
  .mode_neg    (mode_neg),
  .ws_out      (ws_out),
  .sd_true_out (sd_true_out),
  .sd_neg_out  (sd_neg_out),
  .bit_act     (w_bit_act),
  .word_vld    (w_word_vld),
  .cap_word    (w_word),
  .xf_word     (w_xf)
);

// File: tb/serial_negator_test.sv
`timescale 1ns/1ps
module serial_negator_test;

  localparam int WORD  = 16;
  localparam int SLOT  = 18;
  localparam int IDLE  = 3;
  localparam int NFR   = 20;
  localparam int NSL   = 2 * (NFR + 2);
  localparam int N     = IDLE + NSL * SLOT + 2;
  localparam logic [WORD-1:0] MIN_CODE = {1'b1, {(WORD-1){1'b0}}};
  localparam logic [WORD-1:0] MAX_CODE = ~MIN_CODE;

  logic clk = 1'b0;
  logic rst_n;
  logic ws_in, sd_in, mode_neg;
  logic ws_out, sd_true_out, sd_neg_out;

  int total = 0;
  int bad   = 0;

  logic            ws_a [N];
  logic            sd_a [N];
  logic            md_a [N];
  logic            en_a [N];
  string           tag_a [N];
  logic [WORD-1:0] words [NSL];
  int              starts [NSL];

  always #4 clk = ~clk;

  serial_negator #(.WORD(WORD), .SLOT(SLOT)) uut (
    .bck         (clk),
    .rst_n       (rst_n),
    .ws_in       (ws_in),
    .sd_in       (sd_in),
    .mode_neg    (mode_neg),
    .ws_out      (ws_out),
    .sd_true_out (sd_true_out),
    .sd_neg_out  (sd_neg_out)
  );

  function automatic logic [WORD-1:0] ref_xf(logic [WORD-1:0] w, logic m);
    longint v;
    if (!m) return ~w;
    v = (w >= MIN_CODE) ? longint'(w) - (longint'(1) << WORD) : longint'(w);
    v = -v;
    if (v > longint'(MAX_CODE)) v = longint'(MAX_CODE);
    return WORD'(v);
  endfunction

  function automatic logic [WORD-1:0] pick(int s);
    if (s >= 2 * NFR) return '0;
    case (s)
      0, 5, 18: return MIN_CODE;
      1, 19:    return MAX_CODE;
      2:        return '0;
      3:        return {{(WORD-1){1'b0}}, 1'b1};
      4:        return '1;
      default:  return WORD'($urandom);
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t;
    logic ch, m;
    logic [WORD-1:0] prev [2];
    string ptag [2];

    // stimulus and expected stream, built from the requirements
    for (int k = 0; k < N; k++) begin
      ws_a[k] = 1'b0; sd_a[k] = 1'($urandom); md_a[k] = 1'b1;
      en_a[k] = 1'b0; tag_a[k] = "R6";
    end
    for (int k = 0; k < IDLE; k++) sd_a[k] = 1'b0;
    t = IDLE;
    for (int s = 0; s < NSL; s++) begin
      ch = (s % 2 == 0);
      m  = !((s / 2) >= 8 && (s / 2) < 14);
      for (int j = 0; j < SLOT; j++) begin
        ws_a[t+j] = ch;
        md_a[t+j] = m;
      end
      words[s]  = pick(s);
      starts[s] = t;
      for (int i = 0; i < WORD; i++) sd_a[t+1+i] = words[s][WORD-1-i];
      t += SLOT;
    end
    prev[0] = '0; prev[1] = '0;
    ptag[0] = "R1"; ptag[1] = "R1";
    for (int s = 0; s < NSL; s++) begin
      t  = starts[s];
      ch = (s % 2 == 0);
      for (int i = 0; i < WORD; i++) begin
        en_a[t+1+i]  = prev[ch][WORD-1-i];
        tag_a[t+1+i] = ptag[ch];
      end
      m = md_a[t+WORD];
      prev[ch] = ref_xf(words[s], m);
      if (!m)                     ptag[ch] = "R5";
      else if (words[s] == MIN_CODE) ptag[ch] = "R4";
      else if (s < 12)            ptag[ch] = "R2";
      else                        ptag[ch] = "R8";
    end

    rst_n = 1'b0; ws_in = 1'b0; sd_in = 1'b1; mode_neg = 1'b1;
    for (int r = 0; r < 3; r++) begin
      @(posedge clk); #2;
      check("R1", ws_out,      1'b0, "ws_out in reset");
      check("R1", sd_true_out, 1'b0, "sd_true_out in reset");
      check("R1", sd_neg_out,  1'b0, "sd_neg_out in reset");
    end

    for (int k = 0; k <= N; k++) begin
      @(negedge clk); #1;
      if (k == 0) rst_n = 1'b1;
      if (k < N) begin
        ws_in = ws_a[k]; sd_in = sd_a[k]; mode_neg = md_a[k];
      end
      @(posedge clk); #2;
      if (k >= 1) begin
        check("R7", ws_out, ws_a[k-1], "ws_out");
        check("R3", sd_true_out, (k - 1 >= 2 * SLOT) ? sd_a[k-1-2*SLOT] : 1'b0, "sd_true_out");
        check(tag_a[k-1], sd_neg_out, en_a[k-1], "sd_neg_out");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule